// File: doc/BRIEF.md
# Serial Mouse Packet Encoder

This block turns one pointer event into a five-byte packet for a serial mouse. The event carries two signed 16-bit motion deltas and three button bits. The bytes go into an internal 256-byte queue, and a receiver channel drains that queue one byte at a time.

The event port uses a valid/ready handshake. After it accepts an event, the encoder writes one byte per clock into the queue and holds ready low until all five bytes are written. The byte order is:

1. A header. It starts at 0x87, and each pressed button clears its own bit.
2. The horizontal delta, clamped to the range -127 to +127.
3. The vertical delta, negated and then clamped to the same range.
4. A zero byte.
5. A zero byte.

The read side shows the byte at the head of the queue together with a flag that is high whenever the queue holds data. A pop strobe advances the queue. A synchronous clear empties the queue.

Top module: `mouse_pkt_top`

## Requirements
- R1: Byte 0 equals 0x87 with bit 2 cleared when ev_btn[2] (left) is 1, bit 1 cleared when ev_btn[1] (middle) is 1, and bit 0 cleared when ev_btn[0] (right) is 1.
- R2: Byte 1 is ev_dx clamped to the range -127..+127, in 8-bit two's complement (for example 200 gives 0x7F and -128 gives 0x81).
- R3: Byte 2 is the negation of ev_dy clamped to the range -127..+127, in 8-bit two's complement (for example ev_dy=3 gives 0xFD, and ev_dy=-32768 gives 0x7F).
- R4: Bytes 3 and 4 are always 0x00. The five bytes enter the queue in the order 0, 1, 2, 3, 4.
- R5: An event is accepted on a clock edge where both ev_valid and ev_ready are high. ev_ready is then low for exactly five cycles, with one byte written per cycle, and is high again on the sixth cycle.
- R6: The queue holds 256 bytes. A write to a full queue is dropped, so the queue contents stay the same.
- R7: A pop from an empty queue presents 0x00 on q_rdata and changes no state. q_avail stays low and later bytes come out in the normal order.
- R8: After a pop that leaves bytes in the queue, q_avail stays high and q_rdata presents the next byte.
- R9: A one-cycle q_clear empties the queue: q_avail goes low and q_rdata reads 0x00. Bytes written after the clear come out in order.
- R10: After reset, ev_ready is high, q_avail is low and q_rdata is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Encoder can take an event |
| ev_dx | input | 16 | Signed horizontal delta |
| ev_dy | input | 16 | Signed vertical delta |
| ev_btn | input | 3 | Buttons pressed: [2] left, [1] middle, [0] right |
| q_clear | input | 1 | Synchronous queue clear |
| q_avail | output | 1 | Queue holds at least one byte |
| q_pop | input | 1 | Remove the head byte |
| q_rdata | output | 8 | Head byte, or 0x00 when the queue is empty |

## Verification
An event is accepted on one edge, and its bytes reach the queue on the five edges that follow. The bench therefore checks ev_ready at the falling edge after acceptance and at each of the next five falling edges. Pop results are combinational from the head of the queue. Each pop is therefore sampled at a falling edge before the strobe is raised, and the effect of the pop (the next byte, or q_avail) is read at the next falling edge after the rising edge that consumed it.

// File: rtl/mpk_pkg.sv
package mpk_pkg;
  localparam int BYTE_W   = 8;
  localparam int PKT_LEN  = 5;
  localparam int CLAMP_MAG = 127;
  localparam logic [BYTE_W-1:0] HDR_BASE = 8'h87;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/mpk_clamp.sv
module mpk_clamp #(
  parameter int IW  = 17,
  parameter int MAG = mpk_pkg::CLAMP_MAG
) (
  input  logic signed [IW-1:0] val_i,
  output mpk_pkg::byte_t       sat_o
);
  localparam logic signed [IW-1:0] HI = IW'(MAG);
  localparam logic signed [IW-1:0] LO = -HI;

  always_comb begin
    if (val_i > HI)      sat_o = HI[mpk_pkg::BYTE_W-1:0];
    else if (val_i < LO) sat_o = LO[mpk_pkg::BYTE_W-1:0];
    else                 sat_o = val_i[mpk_pkg::BYTE_W-1:0];
  end
endmodule

// File: rtl/mpk_packer.sv
module mpk_packer
  import mpk_pkg::*;
#(
  parameter int LEN = PKT_LEN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_valid,
  output logic       ev_ready,
  input  logic [2:0] btn,
  input  byte_t      x_sat,
  input  byte_t      y_sat,
  output logic       push,
  output byte_t      push_data
);
  localparam int IDXW = $clog2(LEN);
  localparam logic [IDXW-1:0] LAST = IDXW'(LEN - 1);

  logic                      busy_q, busy_d;
  logic [IDXW-1:0]           idx_q, idx_d;
  logic [LEN-1:0][BYTE_W-1:0] pkt_q, pkt_d;
  logic                      accept, cap_en;

  assign ev_ready  = !busy_q;
  assign accept    = ev_valid && !busy_q;
  assign cap_en    = accept;
  assign push      = busy_q;
  assign push_data = pkt_q[idx_q];

  always_comb begin
    for (int i = 0; i < LEN; i++) pkt_d[i] = '0;
    pkt_d[0] = HDR_BASE ^ {5'b0, btn};
    pkt_d[1] = x_sat;
    pkt_d[2] = y_sat;
  end

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      if (idx_q == LAST) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) pkt_q <= pkt_d;
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready) |=> (!ev_ready && idx_q == '0)); // R5
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (push && idx_q == LAST) |=> ev_ready); // R5
  AST_HDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (push && idx_q == '0) |-> (push_data[7:3] == 5'b10000)); // R1
  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (push && idx_q > 2) |-> (push_data == '0)); // R4
endmodule

// File: rtl/mpk_queue.sv
module mpk_queue
  import mpk_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  push,
  input  byte_t wdata,
  input  logic  pop,
  output logic  avail,
  output byte_t rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  byte_t            mem [DEPTH];
  logic [AW-1:0]    rptr_q, rptr_d, wptr_q, wptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             wr_ok, rd_ok, full, empty;

  assign full  = (cnt_q == FULL_CNT);
  assign empty = (cnt_q == '0);
  assign wr_ok = push && !full && !clr;
  assign rd_ok = pop && !empty && !clr;
  assign avail = !empty;
  assign rdata = empty ? '0 : mem[rptr_q];

  always_comb begin
    rptr_d = rptr_q;
    wptr_d = wptr_q;
    cnt_d  = cnt_q;
    if (clr) begin
      rptr_d = '0;
      wptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (wr_ok) wptr_d = wptr_q + 1'b1;
      if (rd_ok) rptr_d = rptr_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= wdata;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> ($stable(cnt_q) && $stable(wptr_q))); // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !clr) |=> (cnt_q == '0 && $stable(rptr_q))); // R7
  AST_AVAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q > 1 && pop && !clr) |=> avail); // R8
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !avail); // R9
endmodule

// File: rtl/mouse_pkt_top.sv
module mouse_pkt_top
  import mpk_pkg::*;
#(
  parameter int DELTA_W = 16,
  parameter int QDEPTH  = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid,
  output logic               ev_ready,
  input  logic [DELTA_W-1:0] ev_dx,
  input  logic [DELTA_W-1:0] ev_dy,
  input  logic [2:0]         ev_btn,
  input  logic               q_clear,
  output logic               q_avail,
  input  logic               q_pop,
  output logic [7:0]         q_rdata
);
  localparam int IW = DELTA_W + 1;
  localparam int NAXIS = 2;

  logic signed [IW-1:0] axis_in  [NAXIS];
  byte_t                axis_sat [NAXIS];
  logic                 push;
  byte_t                push_data;

  assign axis_in[0] = $signed({ev_dx[DELTA_W-1], ev_dx});
  assign axis_in[1] = -$signed({ev_dy[DELTA_W-1], ev_dy});

  for (genvar g = 0; g < NAXIS; g++) begin : g_axis
    mpk_clamp #(.IW(IW), .MAG(CLAMP_MAG)) u_clamp (
      .val_i(axis_in[g]),
      .sat_o(axis_sat[g])
    );
  end

  mpk_packer #(.LEN(PKT_LEN)) u_packer (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_valid (ev_valid),
    .ev_ready (ev_ready),
    .btn      (ev_btn),
    .x_sat    (axis_sat[0]),
    .y_sat    (axis_sat[1]),
    .push     (push),
    .push_data(push_data)
  );

  mpk_queue #(.DEPTH(QDEPTH)) u_queue (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (q_clear),
    .push (push),
    .wdata(push_data),
    .pop  (q_pop),
    .avail(q_avail),
    .rdata(q_rdata)
  );

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !q_avail |-> (q_rdata == 8'h00)); // R7
endmodule

// File: tb/mouse_pkt_top_test.sv
`timescale 1ns/1ps
module mouse_pkt_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_valid;
  logic        ev_ready;
  logic [15:0] ev_dx, ev_dy;
  logic [2:0]  ev_btn;
  logic        q_clear, q_avail, q_pop;
  logic [7:0]  q_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mouse_pkt_top uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_dx(ev_dx), .ev_dy(ev_dy), .ev_btn(ev_btn), .q_clear(q_clear),
    .q_avail(q_avail), .q_pop(q_pop), .q_rdata(q_rdata)
  );

  // {btn, dx, dy, byte0, byte1, byte2}
  localparam int NV = 9;
  localparam logic [58:0] VEC [NV] = '{
    {3'b000, 16'h0000, 16'h0000, 8'h87, 8'h00, 8'h00},
    {3'b100, 16'h0005, 16'h0003, 8'h83, 8'h05, 8'hFD},
    {3'b010, 16'hFFFB, 16'hFFFD, 8'h85, 8'hFB, 8'h03},
    {3'b001, 16'h00C8, 16'h0000, 8'h86, 8'h7F, 8'h00},
    {3'b111, 16'hFF38, 16'h00C8, 8'h80, 8'h81, 8'h81},
    {3'b000, 16'h007F, 16'hFF81, 8'h87, 8'h7F, 8'h7F},
    {3'b000, 16'hFF80, 16'hFF80, 8'h87, 8'h81, 8'h7F},
    {3'b101, 16'h8000, 16'h8000, 8'h82, 8'h81, 8'h7F},
    {3'b011, 16'h7FFF, 16'h7FFF, 8'h84, 8'h7F, 8'h81}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] b, input logic [15:0] dx, input logic [15:0] dy);
    @(negedge clk);
    chk("R5 ready before event", ev_ready, 1);
    ev_btn = b; ev_dx = dx; ev_dy = dy; ev_valid = 1'b1;
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R5 ready low after accept", ev_ready, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R5 ready low while emitting", ev_ready, 0);
    end
    @(negedge clk);
    chk("R5 ready back after five bytes", ev_ready, 1);
  endtask

  task automatic pop_byte(output logic [7:0] b, output logic av);
    @(negedge clk);
    av = q_avail;
    b = q_rdata;
    q_pop = 1'b1;
    @(negedge clk);
    q_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic av;
    int n;
    rst_n = 1'b0; ev_valid = 1'b0; ev_dx = '0; ev_dy = '0; ev_btn = '0;
    q_clear = 1'b0; q_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", ev_ready, 1);
    chk("R10 avail after reset", q_avail, 0);
    chk("R10 rdata after reset", q_rdata, 0);

    // Table of events
    for (int v = 0; v < NV; v++) begin
      send(VEC[v][58:56], VEC[v][55:40], VEC[v][39:24]);
      pop_byte(b, av);
      chk("R8 avail with header queued", av, 1);
      chk("R1 header byte", b, VEC[v][23:16]);
      pop_byte(b, av);
      chk("R8 avail after pop", av, 1);
      chk("R2 x byte", b, VEC[v][15:8]);
      pop_byte(b, av);
      chk("R3 y byte", b, VEC[v][7:0]);
      pop_byte(b, av);
      chk("R4 byte 3", b, 0);
      pop_byte(b, av);
      chk("R4 byte 4", b, 0);
      chk("R8 avail before last pop", av, 1);
      @(negedge clk);
      chk("R8 avail after last pop", q_avail, 0);
    end

    // R7: pop while empty
    pop_byte(b, av);
    chk("R7 empty pop data", b, 0);
    chk("R7 empty pop avail", av, 0);
    @(negedge clk);
    chk("R7 avail still low", q_avail, 0);
    chk("R7 rdata still zero", q_rdata, 0);
    send(3'b100, 16'h0002, 16'h0000);
    pop_byte(b, av);
    chk("R7 order after empty pop", b, 8'h83);
    pop_byte(b, av);
    chk("R7 next byte after empty pop", b, 8'h02);

    // R9: clear while holding data
    @(negedge clk);
    q_clear = 1'b1;
    @(negedge clk);
    q_clear = 1'b0;
    chk("R9 avail after clear", q_avail, 0);
    chk("R9 rdata after clear", q_rdata, 0);
    send(3'b001, 16'hFFFF, 16'h0001);
    pop_byte(b, av);
    chk("R9 header after clear", b, 8'h86);
    pop_byte(b, av);
    chk("R9 x after clear", b, 8'hFF);
    pop_byte(b, av);
    chk("R9 y after clear", b, 8'hFF);
    pop_byte(b, av);
    pop_byte(b, av);
    @(negedge clk);
    chk("R9 drained", q_avail, 0);

    // R6: overfill, 52 packets = 260 bytes into 256 entries
    for (int p = 0; p < 51; p++) send(3'b000, 16'h0001, 16'h0000);
    send(3'b111, 16'h0001, 16'h0000);
    n = 0;
    b = 8'h00;
    while (q_avail && n < 300) begin
      pop_byte(b, av);
      n++;
    end
    chk("R6 bytes held when overfilled", n, 256);
    chk("R6 last kept byte is final header", b, 8'h80);
    @(negedge clk);
    chk("R6 empty after drain", q_avail, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule